// File: doc/BRIEF.md
# General-purpose 32-pin I/O bank with atomic set/clear aliases

This block controls 32 pads through a 32-bit register port with byte offsets. Software chooses a direction for each pin, writes the value each output pin drives, and reads the levels on all pins. A pad input passes through two clocked stages before software can read it, so that the register value is stable and safe to use.

Software can also change single output bits without reading the register first. It writes a mask to one of two alias offsets. A 1 in the mask sets or clears the matching output bit, and a 0 leaves it as it is. Because each alias write is a single bus cycle, two pieces of software that own different pins cannot undo each other's changes.

The bus port does one access per cycle. A write takes effect at the clock edge while `bus_we` is high. Read data is combinational from `bus_addr`. Only exact word offsets are decoded. Any other offset inside the 0x100-byte window reads as zero, and a write there has no effect.

Top module: `gpio_alias_bank`

## Requirements
- R1: After reset the direction register is all ones (every pin is an input), the output register is zero, `pad_out` is zero and `pad_hiz` is all ones.
- R2: A read at offset 0x00 returns the revision: major number in bits 7:4, minor number in bits 3:0, and zeros above. A write there has no effect.
- R3: The direction register at 0x34 can be read and written. A 1 bit marks its pin as an input, and `pad_hiz` carries that bit. A 0 bit makes the pin drive.
- R4: The output register at 0x3C can be read and written. Its value appears on `pad_out` one cycle after the write.
- R5: A write at 0x94 sets each output-register bit whose write-data bit is 1 and leaves every other bit unchanged.
- R6: A write at 0x90 clears each output-register bit whose write-data bit is 1 and leaves every other bit unchanged.
- R7: A read at 0x90 or 0x94 returns zero.
- R8: A read at 0x38 returns `pad_in` as it was two clock edges earlier, whatever the direction of each pin. A write at 0x38 has no effect.
- R9: A read at any offset other than 0x00, 0x34, 0x38, 0x3C, 0x90 and 0x94 returns zero. This includes offsets that are not multiples of four. A write at such an offset changes neither the direction register nor the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data or set/clear mask |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Levels on the pads |
| pad_out | output | 32 | Values driven on the pads |
| pad_hiz | output | 32 | 1 means the pad is not driven (input) |

## Verification
The results of this block are due at different times.
- The result of a write (register contents, `pad_out` and `pad_hiz`) appears one clock edge after the edge that samples the strobe. The bench drives every access at a falling edge and checks it at the next falling edge.
- Read data is due in the same cycle as the address, so the bench compares it a moment after the address settles, before any clock edge.
- An input-level read is due two edges after a pad change. The bench keeps its own two-deep history of the pad values it applied. A directed case checks the old value at zero and one edge after a change, and the new value at two edges.

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank #(
  parameter int          PINS      = 32,
  parameter int          AW        = 8,
  parameter logic [3:0]  REV_MAJOR = 4'd2,
  parameter logic [3:0]  REV_MINOR = 4'd1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_hiz
);
  localparam logic [AW-1:0] OFS_REV = 8'h00;
  localparam logic [AW-1:0] OFS_DIR = 8'h34;
  localparam logic [AW-1:0] OFS_LVL = 8'h38;
  localparam logic [AW-1:0] OFS_VAL = 8'h3C;
  localparam logic [AW-1:0] OFS_CLR = 8'h90;
  localparam logic [AW-1:0] OFS_SET = 8'h94;

  logic [PINS-1:0] dir_q, val_q, meta_q, lvl_q;

  wire hit_dir = bus_addr == OFS_DIR;
  wire hit_val = bus_addr == OFS_VAL;
  wire hit_clr = bus_addr == OFS_CLR;
  wire hit_set = bus_addr == OFS_SET;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '1;
      val_q <= '0;
    end else if (bus_we) begin
      if (hit_dir) dir_q <= bus_wdata;
      if (hit_val) val_q <= bus_wdata;
      if (hit_set) val_q <= val_q | bus_wdata;
      if (hit_clr) val_q <= val_q & ~bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= pad_in;
      lvl_q  <= meta_q;
    end

  always_comb
    case (bus_addr)
      OFS_REV: bus_rdata = PINS'({REV_MAJOR, REV_MINOR});
      OFS_DIR: bus_rdata = dir_q;
      OFS_LVL: bus_rdata = lvl_q;
      OFS_VAL: bus_rdata = val_q;
      default: bus_rdata = '0;
    endcase

  assign pad_out = val_q;
  assign pad_hiz = dir_q;

  wire hit_any = bus_addr == OFS_REV || hit_dir || bus_addr == OFS_LVL ||
                 hit_val || hit_clr || hit_set;

  a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_set) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));
  a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_clr) |=> ((pad_out & $past(bus_wdata)) == '0) &&
      ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));
  a_r7_alias_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_clr || hit_set) |-> bus_rdata == '0);
  a_r9_unmapped_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit_any) |=> $stable(pad_out) && $stable(pad_hiz));
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> bus_rdata == '0);
  a_r2_rev_const: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_REV) |-> bus_rdata == PINS'({REV_MAJOR, REV_MINOR}));
endmodule

// File: tb/gpio_alias_bank_test.sv
module gpio_alias_bank_test;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, pad_in = 0;
  logic [31:0] bus_rdata, pad_out, pad_hiz;
  int checks = 0, fails = 0;
  logic [31:0] m_dir, m_val, h1, h2;

  gpio_alias_bank uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_hiz(pad_hiz));

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin h1 <= 0; h2 <= 0; end
    else begin h1 <= pad_in; h2 <= h1; end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return 32'h21;
      8'h34: return m_dir;
      8'h38: return h2;
      8'h3C: return m_val;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
    case (a)
      8'h34: m_dir = d;
      8'h3C: m_val = d;
      8'h94: m_val = m_val | d;
      8'h90: m_val = m_val & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(string req, logic [7:0] a);
    bus_addr = a; bus_we = 0; #1;
    chk(req, bus_rdata, exp_rd(a));
  endtask

  task automatic pins(string req);
    chk({req, " pad_out"}, pad_out, m_val);
    chk({req, " pad_hiz"}, pad_hiz, m_dir);
  endtask

  initial begin
    logic [7:0] addrs [8] = '{8'h00, 8'h34, 8'h38, 8'h3C, 8'h90, 8'h94, 8'h35, 8'hC8};
    void'($urandom(32'd1234));
    m_dir = '1; m_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    pins("R1 reset");
    rd("R1 dir reset", 8'h34);
    rd("R1 val reset", 8'h3C);
    rd("R2 revision", 8'h00);
    wr(8'h00, 32'hFFFF_FFFF); rd("R2 write ignored", 8'h00);
    wr(8'h34, 32'h0F0F_00FF); pins("R3 dir write"); rd("R3 dir read", 8'h34);
    wr(8'h3C, 32'hA5A5_1234); pins("R4 val write"); rd("R4 val read", 8'h3C);
    wr(8'h94, 32'h0000_FFFF); pins("R5 set"); rd("R5 set read", 8'h3C);
    wr(8'h94, 32'h0); pins("R5 empty set");
    wr(8'h90, 32'hFF00_0001); pins("R6 clear"); rd("R6 clear read", 8'h3C);
    wr(8'h90, 32'hFFFF_FFFF); pins("R6 clear all");
    rd("R7 clr alias", 8'h90); rd("R7 set alias", 8'h94);
    wr(8'h3C, 32'h1357_9BDF);
    wr(8'h37, 32'hDEAD_BEEF); pins("R9 unaligned write"); rd("R9 unaligned read", 8'h37);
    wr(8'hFC, 32'h0); pins("R9 unmapped write"); rd("R9 unmapped read", 8'hFC);
    wr(8'h38, 32'hFFFF_FFFF); pins("R8 write ignored");
    pad_in = 32'hCAFE_F00D;
    @(negedge clk);
    pad_in = 32'h0BAD_CAFE;
    bus_addr = 8'h38; #1;
    chk("R8 still old", bus_rdata, 32'h0);
    @(negedge clk); #1;
    chk("R8 two edges", bus_rdata, 32'hCAFE_F00D);
    @(negedge clk); #1;
    chk("R8 next", bus_rdata, 32'h0BAD_CAFE);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      @(negedge clk);
      pad_in = $urandom;
      a = ($urandom % 5 == 0) ? 8'($urandom) : addrs[$urandom % 8];
      if ($urandom % 2) begin
        wr(a, $urandom);
        pins("R5 R6 random write");
      end
      rd("R8 R9 random read", addrs[$urandom % 8]);
      rd("R9 random addr", 8'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule